// File: doc/BRIEF.md
# Phase-Selecting Fractional Clock Divider Controller

This block is the digital controller of a fractional clock divider. A delay line supplies 64 evenly spaced phases of a fast reference clock. The controller runs on the reference clock and decides, for each output period, which phase carries the next output edge. Every output period lasts 64 plus an effective divisor phase steps, so the output frequency is Fref/(1+D/64). That covers Fref down to about 0.504 Fref, in steps of 1/64.

The controller keeps a 6-bit phase pointer that wraps modulo 64. At each output edge it adds the effective divisor, and a carry out of the pointer costs one more whole reference cycle before the next edge. A signed per-period adjust nudges a single period by +2, +1 or -1 steps. Slide commands shift the edge by one step for one period only, so the long-term frequency is unchanged.

A group of these dividers stays idle until a common start request arrives while every delay line in the group reports lock. All of them then begin on the same cycle at phase 0. The analog delay line, the phase multiplexer and clock distribution are outside this block. Here, the position of an edge is the reference cycle index times 64 plus the phase select.

Top module: `phase_step_divider`

## Requirements
- R1: After reset `edgeStrobe`, `phaseSel` and `adjClamped` are 0. The block stays idle, with no strobe and slide commands ignored, until `startReq` is high in the same cycle as every bit of `lockVec`.
- R2: In the cycle after the clock edge that samples that start condition, `edgeStrobe` is 1 and `phaseSel` is 0. From then on `startReq` and `lockVec` have no effect until reset.
- R3: Take the position of a strobe as cycle index × 64 + `phaseSel`. Two successive strobes are then 64 + S phase steps apart, where S is the effective step chosen at the first of them (R5 to R8). At most one cycle without a strobe lies between two strobes.
- R4: `divisor`, `periodAdj` and the slide inputs decide a step only in a cycle where `edgeStrobe` is 1. Values of `divisor` and `periodAdj` in other cycles have no effect.
- R5: `periodAdj` is a 2-bit code: 00 adds 0, 01 adds +1, 10 adds +2 and 11 adds -1 to `divisor`. The code applies only to the period that starts at that strobe.
- R6: If `divisor` plus the adjust falls below 0 or rises above 63, it is clamped to 0 or 63. `adjClamped` is then 1 in the cycle right after that strobe cycle, and it is 0 in every other cycle.
- R7: `slideUp` lengthens the next period that starts after the command by one step. `slideDn` shortens it by one step. Commands are kept pending, saturate at one step in either direction and cancel each other, and the step after a slide returns to the unslid value.
- R8: A pending down slide is held, and not lost, while the clamped divisor is 0. It applies at the first strobe where the clamped divisor is 1 or more.
- R9: `phaseSel` wraps modulo 64 without limit, and the spacing rule of R3 holds across every wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle equals 64 phase steps |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Group start request |
| lockVec | input | LOCK_COUNT | Lock flags of the delay lines in the group |
| divisor | input | PHASE_BITS | Divisor D, 0..63 |
| periodAdj | input | 2 | Per-period adjust code (R5) |
| slideUp | input | 1 | Move the edge one phase step later |
| slideDn | input | 1 | Move the edge one phase step earlier |
| phaseSel | output | PHASE_BITS | Phase used by the current edge |
| edgeStrobe | output | 1 | High in each reference cycle that holds an output edge |
| adjClamped | output | 1 | Pulse that flags a clamped divisor (R6) |

## Verification
The assertions check several rules on every cycle: the idle state is kept without a qualified start, the first strobe follows the start, and no two strobe-free cycles occur in a row. They also check that the pointer holds between edges, that the clamp flag appears only after an edge, that the pending slide stays within one step, and that a down slide is held at a zero divisor. Exact edge spacing can only be shown by the bench's scenarios, which compare it with 64 plus the expected step. So can the effect of the adjust codes and the clamping at both ends, the one-period effect of slides, cancellation and saturation, and the absence of any effect from inputs changed between edges or from start and lock toggled after start.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE   = 2'b00,
    ADJ_PLUS1  = 2'b01,
    ADJ_PLUS2  = 2'b10,
    ADJ_MINUS1 = 2'b11
  } adj_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic active;   // divider running
    logic load;     // synchronous start: pointer to phase 0
    logic edgeNow;  // current cycle carries an output edge
  } ctrl_s;

endpackage

// File: rtl/psdiv_ctrl.sv
module psdiv_ctrl
  import psdiv_pkg::*;
#(
  parameter int LOCK_COUNT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  startReq,
  input  logic [LOCK_COUNT-1:0] lockVec,
  input  logic                  extraCycle,
  output ctrl_s                 ctrlOut,
  output logic                  edgeStrobe
);

  logic runQ;
  logic edgeQ;
  logic holdQ;
  logic allLocked;
  logic goNow;

  assign allLocked = &lockVec;
  assign goNow     = !runQ && startReq && allLocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runQ  <= 1'b0;
      edgeQ <= 1'b0;
      holdQ <= 1'b0;
    end else if (goNow) begin
      runQ  <= 1'b1;
      edgeQ <= 1'b1;
      holdQ <= 1'b0;
    end else if (runQ) begin
      if (edgeQ) begin
        edgeQ <= !extraCycle;
        holdQ <= extraCycle;
      end else if (holdQ) begin
        edgeQ <= 1'b1;
        holdQ <= 1'b0;
      end
    end
  end

  assign ctrlOut.active  = runQ;
  assign ctrlOut.load    = goNow;
  assign ctrlOut.edgeNow = edgeQ;
  assign edgeStrobe      = edgeQ;

  // R1: without a qualified start the divider stays idle
  a_r1_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!runQ && !(startReq && allLocked)) |=> !runQ);

  // R2: the first strobe comes right after the start
  a_r2_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(runQ) |-> edgeQ);

  // R3: never two strobe-free cycles in a row while running
  a_r3_one_gap_max: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !edgeQ) |=> edgeQ);

endmodule

// File: rtl/psdiv_datapath.sv
module psdiv_datapath
  import psdiv_pkg::*;
#(
  parameter int PHASE_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrl_s                 ctrlIn,
  input  logic [PHASE_BITS-1:0] divisor,
  input  logic [1:0]            periodAdj,
  input  logic                  slideUp,
  input  logic                  slideDn,
  output logic [PHASE_BITS-1:0] phaseSel,
  output logic                  extraCycle,
  output logic                  adjClamped
);

  localparam int NUM_PHASES = 1 << PHASE_BITS;
  localparam int SW         = PHASE_BITS + 2;
  localparam int STW        = PHASE_BITS + 1;
  localparam logic signed [SW-1:0] MAX_DIV = SW'(NUM_PHASES - 1);

  logic [PHASE_BITS-1:0] ptrQ;
  logic signed [1:0]     pendQ;
  logic                  ovfQ;

  logic signed [SW-1:0]  adjVal;
  logic signed [SW-1:0]  rawDiv;
  logic [PHASE_BITS-1:0] effDiv;
  logic                  clampHit;
  logic [STW-1:0]        step;
  logic                  consumed;
  logic [STW-1:0]        sum;
  logic signed [2:0]     pendBase;
  logic signed [2:0]     pendSum;
  logic signed [1:0]     pendNext;

  always_comb begin
    case (adj_e'(periodAdj))
      ADJ_PLUS1:  adjVal = SW'(1);
      ADJ_PLUS2:  adjVal = SW'(2);
      ADJ_MINUS1: adjVal = '1;
      default:    adjVal = '0;
    endcase
  end

  assign rawDiv = $signed({2'b00, divisor}) + adjVal;

  always_comb begin
    clampHit = 1'b0;
    effDiv   = rawDiv[PHASE_BITS-1:0];
    if (rawDiv < 0) begin
      effDiv   = '0;
      clampHit = 1'b1;
    end else if (rawDiv > MAX_DIV) begin
      effDiv   = '1;
      clampHit = 1'b1;
    end
  end

  always_comb begin
    step     = {1'b0, effDiv};
    consumed = 1'b0;
    if (pendQ == 2'sb01) begin
      step     = {1'b0, effDiv} + STW'(1);
      consumed = 1'b1;
    end else if (pendQ == 2'sb11 && effDiv != '0) begin
      step     = {1'b0, effDiv} - STW'(1);
      consumed = 1'b1;
    end
  end

  assign sum        = {1'b0, ptrQ} + step;
  assign extraCycle = sum[PHASE_BITS];

  always_comb begin
    pendBase = (ctrlIn.edgeNow && consumed) ? 3'sd0 : {pendQ[1], pendQ};
    pendSum  = pendBase + (slideUp ? 3'sd1 : 3'sd0) - (slideDn ? 3'sd1 : 3'sd0);
    if (pendSum > 3'sd1)       pendNext = 2'sb01;
    else if (pendSum < -3'sd1) pendNext = 2'sb11;
    else                       pendNext = pendSum[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ  <= '0;
      pendQ <= '0;
      ovfQ  <= 1'b0;
    end else if (ctrlIn.load) begin
      ptrQ  <= '0;
      pendQ <= '0;
      ovfQ  <= 1'b0;
    end else if (ctrlIn.active) begin
      pendQ <= pendNext;
      ovfQ  <= ctrlIn.edgeNow && clampHit;
      if (ctrlIn.edgeNow) ptrQ <= sum[PHASE_BITS-1:0];
    end
  end

  assign phaseSel   = ptrQ;
  assign adjClamped = ovfQ;

  // R4: the pointer moves only at an edge or at the start
  a_r4_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlIn.edgeNow && !ctrlIn.load) |=> $stable(ptrQ));

  // R6: the clamp flag follows an edge cycle
  a_r6_clamp_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ovfQ |-> $past(ctrlIn.edgeNow));

  // R7: the pending slide never exceeds one step
  a_r7_pend_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pendQ != 2'sb10);

  // R8: a down slide is held while the divisor is zero
  a_r8_early_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIn.active && ctrlIn.edgeNow && pendQ == 2'sb11 && effDiv == '0 && !slideUp)
      |=> pendQ == 2'sb11);

endmodule

// File: rtl/phase_step_divider.sv
module phase_step_divider
  import psdiv_pkg::*;
#(
  parameter int PHASE_BITS = 6,
  parameter int LOCK_COUNT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  startReq,
  input  logic [LOCK_COUNT-1:0] lockVec,
  input  logic [PHASE_BITS-1:0] divisor,
  input  logic [1:0]            periodAdj,
  input  logic                  slideUp,
  input  logic                  slideDn,
  output logic [PHASE_BITS-1:0] phaseSel,
  output logic                  edgeStrobe,
  output logic                  adjClamped
);

  ctrl_s ctrlBus;
  logic  extraCycle;

  psdiv_ctrl #(.LOCK_COUNT(LOCK_COUNT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .lockVec    (lockVec),
    .extraCycle (extraCycle),
    .ctrlOut    (ctrlBus),
    .edgeStrobe (edgeStrobe)
  );

  psdiv_datapath #(.PHASE_BITS(PHASE_BITS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlIn     (ctrlBus),
    .divisor    (divisor),
    .periodAdj  (periodAdj),
    .slideUp    (slideUp),
    .slideDn    (slideDn),
    .phaseSel   (phaseSel),
    .extraCycle (extraCycle),
    .adjClamped (adjClamped)
  );

  // R2: the first edge after start sits on phase 0
  a_r2_start_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrlBus.active) |-> (phaseSel == '0));

endmodule

// File: tb/phase_step_divider_tb.sv
`timescale 1ns/1ps
module phase_step_divider_tb;

  localparam int PB = 6;
  localparam int LC = 4;
  localparam int NCYC = 4000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startReq = 1'b0;
  logic [LC-1:0] lockVec = '0;
  logic [PB-1:0] divisor = '0;
  logic [1:0]    periodAdj = '0;
  logic          slideUp = 1'b0;
  logic          slideDn = 1'b0;
  logic [PB-1:0] phaseSel;
  logic          edgeStrobe;
  logic          adjClamped;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  phase_step_divider #(.PHASE_BITS(PB), .LOCK_COUNT(LC)) u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .lockVec(lockVec),
    .divisor(divisor), .periodAdj(periodAdj), .slideUp(slideUp), .slideDn(slideDn),
    .phaseSel(phaseSel), .edgeStrobe(edgeStrobe), .adjClamped(adjClamped)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Effective step from the requirements (R5, R6, R7, R8)
  task automatic stepModel(input int d, input int code, input int pend,
                           output int step, output bit hit, output bit cons);
    int a;
    int r;
    a = (code == 1) ? 1 : (code == 2) ? 2 : (code == 3) ? -1 : 0;
    r = d + a;
    hit = 0;
    if (r < 0) begin r = 0; hit = 1; end
    else if (r > 63) begin r = 63; hit = 1; end
    step = r;
    cons = 0;
    if (pend == 1) begin step = r + 1; cons = 1; end
    else if (pend == -1 && r > 0) begin step = r - 1; cons = 1; end
  endtask

  function automatic int sat1(input int v);
    return (v > 1) ? 1 : (v < -1) ? -1 : v;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint prevPos;
    longint expSpacing;
    longint pos;
    bit     havePrev;
    bit     expOvf;
    int     pend;
    int     gap;
    int     wraps;
    int     lastPhase;
    string  tag;
    void'($urandom(32'd2024));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(edgeStrobe == 0, "R1 reset strobe", edgeStrobe, 0);
    check(phaseSel == 0, "R1 reset phase", phaseSel, 0);
    check(adjClamped == 0, "R1 reset clamp", adjClamped, 0);

    // Start with one lock missing, slides while idle: no effect
    startReq = 1'b1;
    lockVec  = 4'b1011;
    slideUp  = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(edgeStrobe == 0, "R1 idle without all locks", edgeStrobe, 0);
    end
    slideUp = 1'b0;
    lockVec = '1;
    @(negedge clk);
    startReq = 1'b0;
    check(edgeStrobe == 1, "R2 first strobe", edgeStrobe, 1);
    check(phaseSel == 0, "R2 first phase", phaseSel, 0);

    havePrev = 0; expOvf = 0; pend = 0; gap = 0; wraps = 0; lastPhase = 0;
    prevPos = 0; expSpacing = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int d;
      int code;
      bit up;
      bit dn;
      int step;
      bit hit;
      bit cons;
      check(adjClamped == expOvf, "R6 clamp flag", adjClamped, expOvf);
      if (edgeStrobe) begin
        gap = 0;
        pos = longint'(cyc) * 64 + phaseSel;
        if (havePrev)
          check(pos - prevPos == expSpacing, tag, pos - prevPos, expSpacing);
        if (havePrev && phaseSel < lastPhase) wraps++;
        lastPhase = phaseSel;
      end else begin
        gap++;
        check(gap < 2, "R3 strobe gap", gap, 1);
      end

      if (cyc < 400) begin
        d = 0; code = ($urandom % 2) ? 3 : 0;
        up = 0; dn = ($urandom % 4) == 0;
      end else if (cyc < 800) begin
        d = 63; code = $urandom % 4;
        up = ($urandom % 5) == 0; dn = 0;
      end else begin
        d = $urandom % 64; code = $urandom % 4;
        up = ($urandom % 7) == 0; dn = ($urandom % 7) == 0;
      end
      divisor   = PB'(d);
      periodAdj = 2'(code);
      slideUp   = up;
      slideDn   = dn;
      startReq  = 1'($urandom % 2);   // R2: ignored once running
      lockVec   = LC'($urandom);

      expOvf = 0;
      if (edgeStrobe) begin
        stepModel(d, code, pend, step, hit, cons);
        expOvf     = hit;
        expSpacing = 64 + step;
        tag = "R3 R4 R9 spacing";
        if (code != 0) tag = {tag, " R5"};
        if (hit) tag = {tag, " R6"};
        if (pend != 0) tag = {tag, " R7"};
        if (pend == -1 && !cons) tag = {tag, " R8"};
        prevPos  = pos;
        havePrev = 1;
        if (cons) pend = 0;
      end
      pend = sat1(pend + int'(up) - int'(dn));
      @(negedge clk);
    end
    check(wraps > 0, "R9 phase wrapped", wraps, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule